// File: doc/BRIEF.md
# Input-Queued Packet Crossbar

This block connects a set of input ports to a set of output ports. Every input port owns a small queue. A packet is one payload word plus a destination index. The packet at the front of each queue asks for its destination output. Packets whose destinations are all different cross the fabric together in one cycle. When several queue heads want the same output, a rotating-priority arbiter at that output picks one. The losers stay in their queues until a later cycle.

Because each input can only offer its front packet, one stuck head also holds back every packet queued behind it. This happens even when those packets target idle outputs, so the block shows head-of-line blocking directly. Each port uses a valid/ready handshake. A transfer happens on a clock edge where both valid and ready are high. The destination index selects the output and does not appear on the output side.

Top module: `xbar_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, every out_valid bit is 0 and every in_ready bit is 1.
- R2: A packet accepted at an edge with an empty queue in front of it appears on its output in the cycle after that edge. Packets from different inputs to different outputs all appear in that same cycle.
- R3: Input destination value k (binary, DEST_W bits) routes the packet to output k. out_data carries exactly the accepted in_data word.
- R4: Each output grants at most one input per cycle, and each input is granted by at most one output. A packet that loses arbitration stays queued and is delivered later, never dropped.
- R5: Output arbitration is round-robin. After reset, input 0 has top priority. After a transfer from input g, top priority moves to input g+1, wrapping to 0 after N_IN-1. With inputs 0 and 2 each holding two packets for one output, the delivery order is 0, 2, 0, 2.
- R6: While an output shows out_valid high with out_ready low, its out_data stays unchanged in the next cycle and the offered packet is not replaced. This holds even if a higher-priority input starts requesting.
- R7: A queue head waiting on a stalled output keeps the later packets of the same input from leaving, even when their output is idle. Other inputs still reach that idle output.
- R8: An input holding FIFO_DEPTH packets drives in_ready low. An in_valid word offered while in_ready is low is not stored and never appears at any output.
- R9: Packets from one input to one output leave in the order they were accepted. After the outputs drain, every accepted packet has left exactly once.
- R10: With all inputs saturating one ready output, the served inputs cycle 0, 1, 2, 3, 0, ... so no waiting input is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_IN | Per-input packet valid |
| in_ready | output | N_IN | Per-input space available |
| in_dest | input | N_IN x DEST_W | Per-input destination output index |
| in_data | input | N_IN x DATA_W | Per-input payload word |
| out_valid | output | N_OUT | Per-output packet valid |
| out_ready | input | N_OUT | Per-output sink ready |
| out_data | output | N_OUT x DATA_W | Per-output payload word |

## Verification
Some internal faults show up at the ports in a fixed number of cycles:

- A wrong priority pointer changes the order of deliveries on a contended output in the very next transfer.
- A grant that is not held during a stall changes out_data in the following cycle.

Other faults take longer to surface:

- A queue counter or pointer fault shows up as a lost, repeated or reordered packet. This may appear only several transfers later, once the queue wraps.
- Such faults also show up as a wrong in_ready at the fill boundary.

The bench therefore compares whole delivery sequences per flow, checks the exact cycle at which outputs become valid, and checks stall and full conditions at the cycle they should take effect.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_mode_e;

    // Index width with a floor of one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must reach n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/xbar_in_fifo.sv
module xbar_in_fifo
    import xbar_pkg::*;
#(
    parameter int unsigned WIDTH = 10,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    input  logic             pop
);
    localparam int unsigned AW = idx_width(DEPTH);
    localparam int unsigned CW = cnt_width(DEPTH);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             push, take;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign in_ready   = (cnt_q != CW'(DEPTH));
    assign head_valid = (cnt_q != '0);
    assign head_data  = store_q[rd_q];
    assign push       = in_valid & in_ready;
    assign take       = pop & head_valid;

    always_ff @(posedge clk) begin
        if (push) begin
            store_q[wr_q] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (take) rd_q <= bump(rd_q);
            case ({push, take})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: occupancy never exceeds the configured depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R4: the switch only removes a packet that is actually queued
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid);

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
    import xbar_pkg::*;
#(
    parameter int unsigned N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic             adv,
    output logic [N_REQ-1:0] gnt
);
    localparam int unsigned IW = idx_width(N_REQ);

    logic [IW-1:0]    prio_q;
    arb_mode_e        mode_q;
    logic [N_REQ-1:0] held_q;
    logic [N_REQ-1:0] pick;
    logic [IW-1:0]    win_idx;
    logic [IW-1:0]    next_prio;
    int unsigned      j;

    // First requester at or after the priority pointer, cyclically.
    always_comb begin
        pick = '0;
        j    = 0;
        for (int k = N_REQ - 1; k >= 0; k--) begin
            j = (int'(prio_q) + k) % N_REQ;
            if (req[IW'(j)]) begin
                pick          = '0;
                pick[IW'(j)]  = 1'b1;
            end
        end
    end

    assign gnt = (mode_q == ARB_HOLD) ? held_q : pick;

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt[i]) win_idx = IW'(i);
        end
        next_prio = (win_idx == IW'(N_REQ - 1)) ? '0 : win_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            mode_q <= ARB_FREE;
            held_q <= '0;
        end else if (adv) begin
            prio_q <= next_prio;
            mode_q <= ARB_FREE;
        end else if (|gnt) begin
            mode_q <= ARB_HOLD;
            held_q <= gnt;
        end else begin
            mode_q <= ARB_FREE;
        end
    end

    // R4: one winner per output at most
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R4: a grant only goes to an input that asks for this output
    a_r4_grant_requested: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R5: after a transfer with other requesters waiting, the winner changes
    a_r5_rotate: assert property (@(posedge clk) disable iff (rst)
        (adv && ((req & ~gnt) != '0)) |=> (gnt != $past(gnt)));

    // R6: a stalled offer keeps its winner
    a_r6_hold_winner: assert property (@(posedge clk) disable iff (rst)
        ((|gnt) && !adv) |=> (gnt == $past(gnt)));

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
    import xbar_pkg::*;
#(
    parameter int unsigned N_IN       = 4,
    parameter int unsigned N_OUT      = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned DEST_W    = idx_width(N_OUT)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [N_IN-1:0]                in_valid,
    output logic [N_IN-1:0]                in_ready,
    input  logic [N_IN-1:0][DEST_W-1:0]    in_dest,
    input  logic [N_IN-1:0][DATA_W-1:0]    in_data,
    output logic [N_OUT-1:0]               out_valid,
    input  logic [N_OUT-1:0]               out_ready,
    output logic [N_OUT-1:0][DATA_W-1:0]   out_data
);
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] payload;
    } cell_t;

    localparam int unsigned CELL_W = $bits(cell_t);

    cell_t                          head_cell [N_IN];
    logic [N_IN-1:0]                head_valid;
    logic [N_IN-1:0]                pop;
    logic [N_OUT-1:0][N_IN-1:0]     req_m;
    logic [N_OUT-1:0][N_IN-1:0]     gnt_m;
    logic [N_IN-1:0][N_OUT-1:0]     gnt_t;

    // Input side: one queue per port
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        cell_t             push_cell;
        logic [CELL_W-1:0] head_raw;

        assign push_cell = '{dest: in_dest[gi], payload: in_data[gi]};

        xbar_in_fifo #(
            .WIDTH (CELL_W),
            .DEPTH (FIFO_DEPTH)
        ) fifo_i (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid[gi]),
            .in_ready   (in_ready[gi]),
            .in_data    (push_cell),
            .head_valid (head_valid[gi]),
            .head_data  (head_raw),
            .pop        (pop[gi])
        );

        assign head_cell[gi] = cell_t'(head_raw);

        // R4: an input is granted by no more than one output
        a_r4_input_single_grant: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt_t[gi]));

        // R8: ready can only drop right after a word was offered
        a_r8_ready_fall: assert property (@(posedge clk) disable iff (rst)
            $fell(in_ready[gi]) |-> $past(in_valid[gi]));
    end

    // Crosspoint request matrix and dequeue decision
    always_comb begin
        pop = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < N_IN; i++) begin
                req_m[o][i] = head_valid[i] && (head_cell[i].dest == DEST_W'(o));
                gnt_t[i][o] = gnt_m[o][i];
                pop[i]      = pop[i] | (gnt_m[o][i] & out_ready[o]);
            end
        end
    end

    // Output side: one arbiter and one column multiplexer per port
    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        logic [DATA_W-1:0] sel_data;

        xbar_rr_arb #(
            .N_REQ (N_IN)
        ) arb_i (
            .clk (clk),
            .rst (rst),
            .req (req_m[go]),
            .adv (out_valid[go] & out_ready[go]),
            .gnt (gnt_m[go])
        );

        always_comb begin
            sel_data = '0;
            for (int i = 0; i < N_IN; i++) begin
                if (gnt_m[go][i]) sel_data = sel_data | head_cell[i].payload;
            end
        end

        assign out_valid[go] = |gnt_m[go];
        assign out_data[go]  = sel_data;

        // R6: a stalled output keeps offering the same word
        a_r6_stall_stable: assert property (@(posedge clk) disable iff (rst)
            (out_valid[go] && !out_ready[go]) |=> (out_valid[go] && $stable(out_data[go])));
    end

endmodule

// File: tb/xbar_switch_tb.sv
`timescale 1ns/1ps
module xbar_switch_tb_top;
    localparam int N = 4;
    localparam int M = 4;
    localparam int W = 8;
    localparam int D = 4;
    localparam int DW = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N-1:0]         in_valid = '0;
    logic [N-1:0]         in_ready;
    logic [N-1:0][DW-1:0] in_dest = '0;
    logic [N-1:0][W-1:0]  in_data = '0;
    logic [M-1:0]         out_valid;
    logic [M-1:0]         out_ready = '1;
    logic [M-1:0][W-1:0]  out_data;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] rx_q  [M][$];
    logic [W-1:0] exp_q [N][M][$];

    always #2.5 clk = ~clk;

    xbar_switch #(
        .N_IN(N), .N_OUT(M), .DATA_W(W), .FIFO_DEPTH(D)
    ) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Record every output transfer, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int o = 0; o < M; o++) begin
                if (out_valid[o] && out_ready[o]) rx_q[o].push_back(out_data[o]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        in_valid  = '0;
        out_ready = '1;
        rst       = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        for (int o = 0; o < M; o++) rx_q[o].delete();
    endtask

    task automatic drive(input int i, input int dest, input int data);
        in_valid[i] = 1'b1;
        in_dest[i]  = DW'(dest);
        in_data[i]  = W'(data);
    endtask

    // R1, R2, R3: reset state and a conflict-free permutation
    task automatic t_permutation();
        do_reset();
        @(negedge clk);
        check(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == '1, "R1", "in_ready after reset", in_ready, 4'hF);
        step();
        for (int i = 0; i < N; i++) drive(i, (i + 1) % M, 8'h10 + i);
        step();
        in_valid = '0;
        @(negedge clk);
        check(out_valid == 4'hF, "R2", "all outputs valid together", out_valid, 4'hF);
        for (int o = 0; o < M; o++) begin
            check(out_data[o] == W'(8'h10 + ((o + M - 1) % M)), "R3", "routed payload",
                  out_data[o], 8'h10 + ((o + M - 1) % M));
        end
        step();
        @(negedge clk);
        check(out_valid == '0, "R2", "outputs idle after one transfer", out_valid, 0);
        step();
    endtask

    // R5: rotation between two contending inputs
    task automatic t_round_robin();
        do_reset();
        drive(0, 0, 8'h00);
        drive(2, 0, 8'h80);
        step();
        drive(0, 0, 8'h01);
        drive(2, 0, 8'h81);
        step();
        in_valid = '0;
        repeat (6) step();
        check(rx_q[0].size() == 4, "R5", "delivered count", rx_q[0].size(), 4);
        if (rx_q[0].size() == 4) begin
            check(rx_q[0][0] == 8'h00, "R5", "order slot 0", rx_q[0][0], 8'h00);
            check(rx_q[0][1] == 8'h80, "R5", "order slot 1", rx_q[0][1], 8'h80);
            check(rx_q[0][2] == 8'h01, "R5", "order slot 2", rx_q[0][2], 8'h01);
            check(rx_q[0][3] == 8'h81, "R5", "order slot 3", rx_q[0][3], 8'h81);
        end
    endtask

    // R7: head-of-line blocking on input 0
    task automatic t_hol();
        do_reset();
        out_ready = 4'b1101;
        drive(0, 1, 8'h0A);
        step();
        drive(0, 2, 8'h0B);
        drive(1, 2, 8'h4C);
        step();
        in_valid = '0;
        repeat (3) step();
        @(negedge clk);
        check(rx_q[2].size() == 1 && rx_q[2][0] == 8'h4C, "R7", "other input reaches idle output",
              rx_q[2].size(), 1);
        check(out_valid[2] == 1'b0, "R7", "blocked packet held back", out_valid[2], 0);
        check(out_valid[1] && out_data[1] == 8'h0A, "R7", "stuck head offered", out_data[1], 8'h0A);
        step();
        out_ready = '1;
        step();
        @(negedge clk);
        check(out_valid[2] && out_data[2] == 8'h0B, "R7", "released follower", out_data[2], 8'h0B);
        step();
        check(rx_q[1].size() == 1 && rx_q[1][0] == 8'h0A, "R7", "head delivered once",
              rx_q[1].size(), 1);
    endtask

    // R8, R9: full queue refuses further words
    task automatic t_full();
        do_reset();
        out_ready[0] = 1'b0;
        for (int k = 0; k < D; k++) begin
            drive(0, 0, 8'h10 + k);
            step();
        end
        in_valid = '0;
        @(negedge clk);
        check(in_ready[0] == 1'b0, "R8", "ready low when full", in_ready[0], 0);
        step();
        drive(0, 0, 8'hEE);
        repeat (3) step();
        in_valid = '0;
        check(in_ready[0] == 1'b0, "R8", "ready still low", in_ready[0], 0);
        check(rx_q[0].size() == 0, "R8", "nothing sent while stalled", rx_q[0].size(), 0);
        out_ready = '1;
        repeat (8) step();
        check(rx_q[0].size() == D, "R8", "refused word not stored", rx_q[0].size(), D);
        for (int k = 0; k < D && k < rx_q[0].size(); k++) begin
            check(rx_q[0][k] == W'(8'h10 + k), "R9", "fifo order", rx_q[0][k], 8'h10 + k);
        end
    endtask

    // R6: stalled output keeps its offer against a higher-priority newcomer
    task automatic t_stall();
        do_reset();
        out_ready[0] = 1'b0;
        drive(2, 0, 8'h85);
        step();
        in_valid = '0;
        @(negedge clk);
        check(out_valid[0] && out_data[0] == 8'h85, "R6", "first offer", out_data[0], 8'h85);
        step();
        drive(0, 0, 8'h01);
        step();
        in_valid = '0;
        step();
        @(negedge clk);
        check(out_valid[0] && out_data[0] == 8'h85, "R6", "offer not displaced", out_data[0], 8'h85);
        step();
        out_ready = '1;
        repeat (4) step();
        check(rx_q[0].size() == 2 && rx_q[0][0] == 8'h85 && rx_q[0][1] == 8'h01, "R6",
              "delivery after stall", rx_q[0].size(), 2);
    endtask

    // R10: four inputs saturating output 0
    task automatic t_saturate();
        int seq [N];
        bit ord_ok;
        int last_seq [N];
        do_reset();
        for (int i = 0; i < N; i++) begin
            seq[i] = 0;
            last_seq[i] = -1;
        end
        for (int c = 0; c < 24; c++) begin
            for (int i = 0; i < N; i++) drive(i, 0, {2'(i), 6'(seq[i])});
            @(negedge clk);
            for (int i = 0; i < N; i++) if (in_ready[i]) seq[i]++;
            step();
        end
        in_valid = '0;
        repeat (40) step();
        check(rx_q[0].size() >= 16, "R10", "enough deliveries", rx_q[0].size(), 16);
        for (int k = 0; k < 16 && k < rx_q[0].size(); k++) begin
            check(int'(rx_q[0][k][7:6]) == (k % N), "R10", "service rotation",
                  rx_q[0][k][7:6], k % N);
        end
        ord_ok = 1'b1;
        for (int k = 0; k < rx_q[0].size(); k++) begin
            if (int'(rx_q[0][k][5:0]) != last_seq[rx_q[0][k][7:6]] + 1) ord_ok = 1'b0;
            last_seq[rx_q[0][k][7:6]] = int'(rx_q[0][k][5:0]);
        end
        check(ord_ok, "R9", "per-input sequence under saturation", ord_ok, 1);
    endtask

    // R9, R4: mixed traffic with output backpressure
    task automatic t_stream();
        int sent [N];
        int total_sent;
        int total_rx;
        int bad;
        int left;
        logic [W-1:0] w;
        do_reset();
        for (int i = 0; i < N; i++) begin
            sent[i] = 0;
            for (int o = 0; o < M; o++) exp_q[i][o].delete();
        end
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < N; i++) begin
                if (sent[i] < 20) drive(i, (i + sent[i] + sent[i] / 3) % M, {2'(i), 6'(sent[i])});
                else in_valid[i] = 1'b0;
            end
            for (int o = 0; o < M; o++) out_ready[o] = ((c + o) % 3) != 0;
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (in_valid[i] && in_ready[i]) begin
                    exp_q[i][in_dest[i]].push_back(in_data[i]);
                    sent[i]++;
                end
            end
            step();
        end
        in_valid  = '0;
        out_ready = '1;
        repeat (40) step();
        total_sent = 0;
        for (int i = 0; i < N; i++) total_sent += sent[i];
        total_rx = 0;
        bad = 0;
        for (int o = 0; o < M; o++) begin
            total_rx += rx_q[o].size();
            foreach (rx_q[o][k]) begin
                w = rx_q[o][k];
                if (exp_q[w[7:6]][o].size() == 0) bad++;
                else if (exp_q[w[7:6]][o].pop_front() != w) bad++;
            end
        end
        left = 0;
        for (int i = 0; i < N; i++) for (int o = 0; o < M; o++) left += exp_q[i][o].size();
        check(total_sent == 80, "R9", "all words accepted", total_sent, 80);
        check(total_rx == total_sent, "R9", "conservation", total_rx, total_sent);
        check(bad == 0, "R9", "per-flow order", bad, 0);
        check(left == 0, "R4", "no packet left behind", left, 0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_permutation();
        t_round_robin();
        t_hol();
        t_full();
        t_stall();
        t_saturate();
        t_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule